// File: doc/BRIEF.md
# Serial Line Break and Idle Monitor

This block watches an already synchronized asynchronous serial receive line and flags two line conditions whose time scale comes from the configured character format. A break is a low level that lasts at least one whole character time. An idle period is a high level that lasts one whole character time. The character time in clocks is derived live from the data width, parity enable, stop length and clocks-per-bit divisor inputs.

A break is only announced once the line has gone high again. At that point the block also reports how many clocks the low run lasted. The character receiver next to this block uses the break pulse to drop back to hunting for a start bit.

While the line stays high, idle is reported again after every further character time. The receiver steers the idle timing through two pulse inputs:
- A normal end of character restarts the idle measurement at that moment.
- A rejected start bit restarts it half a bit later.

There is no data stream here, so every pin is a plain level or a single-cycle pulse, with no valid/ready handshake. `CNT_W` must be at least `DIV_W`.

Top module: `uart_line_cond`

## Requirements
- R1: The character time F in clocks is ceil(h * bit_clks_i / 2), where h counts half-bit periods: 2 for the start bit, plus 2 per data bit (data_bits_i, binary 5 to 9), plus 2 if parity_en_i is 1, plus stop_half_i (the stop length in half bits, binary 0 to 3). F is saturated to 2^CNT_W-1, and a configuration change is used from the second clock edge onward.
- R2: When the line returns high after a run of N consecutive low samples, a break is reported if N >= F and not reported if N < F.
- R3: break_o is a single-cycle pulse, asserted in the cycle after the first clock edge at which the line is sampled high again. It is never asserted while the line is low.
- R4: With each break pulse, break_len_o takes the value N and holds it until the next break.
- R5: When the line goes high and no idle measurement is running, the measurement starts at the first high sample edge. idle_o then pulses in the cycle after the edge F clocks later.
- R6: While the line stays high, idle_o pulses again every F clocks after the previous report.
- R7: A single low sample cancels a running idle measurement, and the next high level starts a fresh one.
- R8: A frame_end_i pulse while the line is high restarts the idle measurement at that edge, so the report follows F clocks later.
- R9: A start_reject_i pulse while the line is high restarts the idle measurement with a target of F + ceil(bit_clks_i / 2) clocks.
- R10: The low-run counter saturates at 2^CNT_W-1 instead of wrapping. A saturated run still reports a break, with break_len_o equal to 2^CNT_W-1.
- R11: After reset, break_o, idle_o and break_len_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 1 | Synchronized serial line, idle high |
| data_bits_i | input | 4 | Data bits per character, 5 to 9 |
| parity_en_i | input | 1 | 1 when a parity bit is present |
| stop_half_i | input | 2 | Stop length in half bits, 0 to 3 |
| bit_clks_i | input | DIV_W | Clocks per bit |
| frame_end_i | input | 1 | Pulse from the receiver at the nominal end of a character |
| start_reject_i | input | 1 | Pulse from the receiver when a start bit is rejected |
| break_o | output | 1 | Break pulse, also used as the receiver restart |
| break_len_o | output | CNT_W | Length in clocks of the last break |
| idle_o | output | 1 | Idle pulse, once per character time of high level |

## Verification
A wrong character-time value moves both the break threshold and the idle period. It therefore shows up at the first low run of length F-1 or F, and at the first idle pulse, within one character time. A low counter that is stale or wraps shows up as a wrong break_len_o, or as a missing break, in the cycle right after the line rises. A corrupted idle counter or target misplaces the idle_o pulse by a measurable number of clocks, within one character time of the last restart.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
  localparam int HALVES_W = 5;

  // Character length counted in half-bit periods.
  function automatic logic [HALVES_W-1:0] frame_halves(input logic [3:0] data_bits,
                                                       input logic       parity_en,
                                                       input logic [1:0] stop_half);
    return HALVES_W'(2 + 2 * int'(data_bits) + 2 * int'(parity_en) + int'(stop_half));
  endfunction
endpackage

// File: rtl/uart_lc_frame_len.sv
module uart_lc_frame_len
  import uart_lc_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_half_i,
  input  logic [DIV_W-1:0] bit_clks_i,
  output logic [CNT_W-1:0] frame_len_o,
  output logic [DIV_W-1:0] half_bit_o
);
  localparam int PROD_W = DIV_W + HALVES_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   rounded;
  logic [CNT_W-1:0]  len_c;
  logic [DIV_W:0]    half_c;

  always_comb begin
    prod    = PROD_W'(frame_halves(data_bits_i, parity_en_i, stop_half_i)) * PROD_W'(bit_clks_i);
    rounded = ({1'b0, prod} + (PROD_W + 1)'(1)) >> 1;
    half_c  = ({1'b0, bit_clks_i} + (DIV_W + 1)'(1)) >> 1;
  end

  generate
    if (PROD_W + 1 > CNT_W) begin : g_clamp
      assign len_c = (|rounded[PROD_W:CNT_W]) ? {CNT_W{1'b1}} : rounded[CNT_W-1:0];
    end else begin : g_fit
      assign len_c = CNT_W'(rounded);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_len_o <= '0;
      half_bit_o  <= '0;
    end else begin
      frame_len_o <= len_c;
      half_bit_o  <= half_c[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/uart_lc_break_det.sv
module uart_lc_break_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic             break_o,
  output logic [CNT_W-1:0] break_len_o,
  output logic [CNT_W-1:0] low_run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= 1'b1;
      low_run_o   <= '0;
      break_o     <= 1'b0;
      break_len_o <= '0;
    end else begin
      line_q  <= line_i;
      break_o <= 1'b0;
      if (!line_i) begin
        if (line_q)                low_run_o <= CNT_W'(1);
        else if (low_run_o != CNT_MAX) low_run_o <= low_run_o + CNT_W'(1);
      end else if (!line_q && (low_run_o >= frame_len_i)) begin
        break_o     <= 1'b1;
        break_len_o <= low_run_o;
      end
    end
  end
endmodule

// File: rtl/uart_lc_idle_det.sv
module uart_lc_idle_det #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [DIV_W-1:0] half_bit_i,
  input  logic             frame_end_i,
  input  logic             start_reject_i,
  output logic             idle_o
);
  localparam int TW = CNT_W + 1;

  logic          running;
  logic [TW-1:0] elapsed;
  logic [TW-1:0] target;
  logic [TW-1:0] elapsed_nx;

  assign elapsed_nx = elapsed + TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      elapsed <= '0;
      target  <= '0;
      idle_o  <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (!line_i) begin
        running <= 1'b0;
      end else if (frame_end_i || !running) begin
        running <= 1'b1;
        elapsed <= '0;
        target  <= TW'(frame_len_i);
      end else if (start_reject_i) begin
        elapsed <= '0;
        target  <= TW'(frame_len_i) + TW'(half_bit_i);
      end else if (elapsed_nx >= target) begin
        idle_o  <= 1'b1;
        elapsed <= '0;
        target  <= TW'(frame_len_i);
      end else begin
        elapsed <= elapsed_nx;
      end
    end
  end
endmodule

// File: rtl/uart_line_cond.sv
module uart_line_cond #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [3:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_half_i,
  input  logic [DIV_W-1:0] bit_clks_i,
  input  logic             frame_end_i,
  input  logic             start_reject_i,
  output logic             break_o,
  output logic [CNT_W-1:0] break_len_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] frame_len_w;
  logic [DIV_W-1:0] half_bit_w;
  logic [CNT_W-1:0] low_run_w;

  uart_lc_frame_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .data_bits_i(data_bits_i), .parity_en_i(parity_en_i),
    .stop_half_i(stop_half_i), .bit_clks_i(bit_clks_i),
    .frame_len_o(frame_len_w), .half_bit_o(half_bit_w)
  );

  uart_lc_break_det #(.CNT_W(CNT_W)) u_brk (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .frame_len_i(frame_len_w),
    .break_o(break_o), .break_len_o(break_len_o), .low_run_o(low_run_w)
  );

  uart_lc_idle_det #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .frame_len_i(frame_len_w),
    .half_bit_i(half_bit_w), .frame_end_i(frame_end_i),
    .start_reject_i(start_reject_i), .idle_o(idle_o)
  );
endmodule

// File: rtl/uart_line_cond_chk.sv
module uart_line_cond_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_i,
  input logic             break_o,
  input logic             idle_o,
  input logic [CNT_W-1:0] break_len_o,
  input logic [CNT_W-1:0] frame_len_w,
  input logic [CNT_W-1:0] low_run_w
);
  // R3: break only follows a high sample
  p_break_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |-> $past(line_i));

  // R3: single-cycle pulse
  p_break_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |=> !break_o);

  // R2: reported length meets the threshold in force
  p_break_min_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |-> (break_len_o >= $past(frame_len_w)));

  // R5: idle only after a high sample
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(line_i));

  // R10: a low sample never leaves the run counter at zero (no wrap)
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!line_i) |-> (low_run_w != '0));

  // R4: reported length stays put between breaks
  p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !break_o |-> $stable(break_len_o));
endmodule

bind uart_line_cond uart_line_cond_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .break_o(break_o), .idle_o(idle_o),
  .break_len_o(break_len_o), .frame_len_w(frame_len_w), .low_run_w(low_run_w)
);

// File: tb/uart_line_cond_tb.sv
module uart_line_cond_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic [3:0]  dbits = 4'd8;
  logic        par = 1'b0;
  logic [1:0]  stp = 2'd2;
  logic [11:0] bclk = 12'd4;
  logic        fend = 1'b0;
  logic        srej = 1'b0;
  logic        brk, idl, s_brk, s_idl;
  logic [15:0] blen;
  logic [5:0]  s_blen;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_line_cond dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .data_bits_i(dbits), .parity_en_i(par),
    .stop_half_i(stp), .bit_clks_i(bclk), .frame_end_i(fend), .start_reject_i(srej),
    .break_o(brk), .break_len_o(blen), .idle_o(idl)
  );

  uart_line_cond #(.DIV_W(4), .CNT_W(6)) sat_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .data_bits_i(dbits), .parity_en_i(par),
    .stop_half_i(stp), .bit_clks_i(bclk[3:0]), .frame_end_i(fend), .start_reject_i(srej),
    .break_o(s_brk), .break_len_o(s_blen), .idle_o(s_idl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input int d, input int p, input int s, input int b);
    return ((2 + 2 * d + 2 * p + s) * b + 1) / 2;
  endfunction

  task automatic run_low(input int n);
    line = 1'b0;
    repeat (n) @(negedge clk);
    line = 1'b1;
  endtask

  // idle_o must pulse exactly at negedge number 'at' counted from now
  task automatic idle_window(input int at, input string req);
    for (int k = 1; k <= at + 1; k++) begin
      @(negedge clk);
      check(idl == (k == at), req, int'(idl), int'(k == at));
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(brk == 0, "R11 break", int'(brk), 0);
    check(idl == 0, "R11 idle", int'(idl), 0);
    check(blen == 0, "R11 len", int'(blen), 0);

    // R1 R2 R3 R4 R5 R6 sweep over the character format
    for (int d = 5; d <= 9; d++)
      for (int p = 0; p <= 1; p++)
        for (int s = 0; s <= 3; s++)
          for (int b = 1; b <= 4; b++) begin
            dbits = 4'(d); par = 1'(p); stp = 2'(s); bclk = 12'(b);
            f = exp_len(d, p, s, b);
            repeat (3) @(negedge clk);
            run_low(f - 1);
            @(negedge clk);
            check(brk == 0, "R1 R2 short low", int'(brk), 0);
            repeat (2) @(negedge clk);
            run_low(f);
            for (int k = 1; k <= 2 * f + 2; k++) begin
              @(negedge clk);
              if (k == 1) begin
                check(brk == 1, "R1 R2 break at F", int'(brk), 1);
                check(blen == 16'(f), "R4 length", int'(blen), f);
              end
              if (k == 2) check(brk == 0, "R3 pulse width", int'(brk), 0);
              check(idl == (k == f + 1 || k == 2 * f + 1), "R5 R6 idle timing",
                    int'(idl), int'(k == f + 1 || k == 2 * f + 1));
            end
          end

    // directed cases: F = 40, half bit = 2
    dbits = 4'd8; par = 1'b0; stp = 2'd2; bclk = 12'd4;
    f = 40; h = 2;
    repeat (3) @(negedge clk);

    // R7: one low sample restarts the measurement
    run_low(3);
    repeat (10) @(negedge clk);
    run_low(1);
    idle_window(f + 1, "R7 cancel");

    // R8: frame end re-arms
    run_low(3);
    repeat (10) @(negedge clk);
    fend = 1'b1;
    @(negedge clk);
    fend = 1'b0;
    check(idl == 0, "R8 pulse cycle", int'(idl), 0);
    idle_window(f, "R8 frame end arm");

    // R9: rejected start re-arms half a bit later
    run_low(3);
    repeat (10) @(negedge clk);
    srej = 1'b1;
    @(negedge clk);
    srej = 1'b0;
    check(idl == 0, "R9 pulse cycle", int'(idl), 0);
    idle_window(f + h, "R9 reject arm");

    // R4 hold and R10 saturation (small instance max 63)
    repeat (3) @(negedge clk);
    run_low(80);
    @(negedge clk);
    check(brk == 1, "R2 long break", int'(brk), 1);
    check(blen == 16'd80, "R4 long length", int'(blen), 80);
    check(s_brk == 1, "R10 saturated break", int'(s_brk), 1);
    check(s_blen == 6'd63, "R10 saturated length", int'(s_blen), 63);
    run_low(5);
    @(negedge clk);
    check(blen == 16'd80, "R4 held after short low", int'(blen), 80);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule